// File: doc/BRIEF.md
# Integer ALU with Condition Flags

This block is a single-cycle 32-bit integer arithmetic and logic unit with a four-bit condition register beside it. Each cycle it takes a 3-bit operation code, a source operand and the current value of a destination register. It returns a combinational result and a write-enable for the destination. It also keeps the zero, negative, carry and overflow flags in a register.

The supported operations are add, subtract, compare, OR, XOR and bit-test. Compare and bit-test only set flags and never request a write. The flag register loads new values only on a clock edge where `valid` is high and the code selects a supported operation. In every other cycle it keeps its contents.

The flag vector packs the bits as bit 3 = Z (zero), bit 2 = N (negative), bit 1 = C (carry or borrow), bit 0 = V (signed overflow).

Top module: `status_alu`

## Requirements
- R1: Operation code 0 (add) drives `result` = dst + src (mod 2^32) and asserts `wr_en` when `valid` is high.
- R2: For add, C is set when the 32-bit sum is unsigned-less than either operand. V is set when src and dst share a sign bit and the sum's sign bit differs from it.
- R3: Operation code 1 (subtract) drives `result` = dst − src and asserts `wr_en` when `valid` is high. C is set when src is unsigned-greater than dst, so C acts as a borrow.
- R4: For subtract, V is set when the sign bits of src and dst differ and the result's sign bit differs from dst's sign bit.
- R5: Operation code 2 (compare) never asserts `wr_en`. It updates all four flags exactly as subtract would for dst − src.
- R6: Operation codes 3 (OR) and 4 (XOR) drive the bitwise result, assert `wr_en` when `valid` is high, and clear C and V.
- R7: Operation code 5 (bit-test) never asserts `wr_en`. It derives Z and N from src AND dst and clears C and V.
- R8: After any supported operation, Z is set exactly when the 32-bit result is zero, and N equals bit 31 of the result.
- R9: Operation codes 6 and 7 leave the flags unchanged, keep `wr_en` low, and drive `result` to zero.
- R10: When `valid` is low, `wr_en` is low and the flags keep their value on the next edge.
- R11: A synchronous active-high `rst` clears all four flags on the next rising clock edge. Reset takes priority over `valid`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset for the flag register |
| valid | input | 1 | Operation request for this cycle |
| op | input | 3 | Operation code: 0 add, 1 sub, 2 cmp, 3 or, 4 xor, 5 btst |
| src | input | 32 | Source operand (subtrahend for sub and cmp) |
| dst | input | 32 | Current destination register value (minuend for sub and cmp) |
| result | output | 32 | Combinational operation result |
| wr_en | output | 1 | Destination write request |
| flags | output | 4 | Registered {Z, N, C, V} |

## Verification
The hardest case to reach from the ports is a hold: an unsupported code or a low `valid` arriving while the flags are non-zero. To set this up, the stimulus first runs an operation that leaves several flags set, then applies codes 6 and 7 and idle cycles with operands that would otherwise change every flag. Signed-overflow edges need operands placed exactly at the 0x7FFFFFFF/0x80000000 boundary, so directed vectors cover those before a long random run. The random run mixes all eight codes and random `valid`.

// File: rtl/status_alu.sv
module status_alu #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         valid,
  input  logic [2:0]   op,
  input  logic [W-1:0] src,
  input  logic [W-1:0] dst,
  output logic [W-1:0] result,
  output logic         wr_en,
  output logic [3:0]   flags
);
  localparam int MSB = W - 1;
  localparam logic [2:0] OP_ADD = 3'd0;
  localparam logic [2:0] OP_SUB = 3'd1;
  localparam logic [2:0] OP_CMP = 3'd2;
  localparam logic [2:0] OP_OR  = 3'd3;
  localparam logic [2:0] OP_XOR = 3'd4;
  localparam logic [2:0] OP_BT  = 3'd5;

  logic [W-1:0] sum, diff;
  logic add_c, add_v, sub_c, sub_v;
  logic c_n, v_n, known, writes;

  assign sum   = dst + src;
  assign diff  = dst - src;
  assign add_c = (sum < src) || (sum < dst);
  assign add_v = (dst[MSB] == src[MSB]) && (sum[MSB] != dst[MSB]);
  assign sub_c = src > dst;
  assign sub_v = (dst[MSB] != src[MSB]) && (diff[MSB] != dst[MSB]);

  always_comb begin
    result = '0;
    c_n    = 1'b0;
    v_n    = 1'b0;
    known  = 1'b1;
    writes = 1'b0;
    unique case (op)
      OP_ADD: begin result = sum;  c_n = add_c; v_n = add_v; writes = 1'b1; end
      OP_SUB: begin result = diff; c_n = sub_c; v_n = sub_v; writes = 1'b1; end
      OP_CMP: begin result = diff; c_n = sub_c; v_n = sub_v; end
      OP_OR:  begin result = dst | src; writes = 1'b1; end
      OP_XOR: begin result = dst ^ src; writes = 1'b1; end
      OP_BT:  result = dst & src;
      default: known = 1'b0;
    endcase
  end

  assign wr_en = valid && writes;

  always_ff @(posedge clk) begin
    if (rst)
      flags <= 4'b0000;
    else if (valid && known)
      flags <= {result == '0, result[MSB], c_n, v_n};
  end
endmodule

module status_alu_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst,
  input logic         valid,
  input logic [2:0]   op,
  input logic [W-1:0] result,
  input logic         wr_en,
  input logic [3:0]   flags
);
  a_r11_reset_clears: assert property (@(posedge clk) rst |=> flags == 4'b0000);

  a_r10_idle_holds: assert property (@(posedge clk) disable iff (rst)
    !valid |=> $stable(flags));

  a_r10_idle_no_write: assert property (@(posedge clk) disable iff (rst)
    !valid |-> !wr_en);

  a_r9_bad_code_holds: assert property (@(posedge clk) disable iff (rst)
    (valid && op > 3'd5) |=> $stable(flags));

  a_r5_r7_no_write: assert property (@(posedge clk) disable iff (rst)
    (op == 3'd2 || op == 3'd5) |-> !wr_en);

  a_r6_logic_clears_cv: assert property (@(posedge clk) disable iff (rst)
    (valid && (op == 3'd3 || op == 3'd4 || op == 3'd5)) |=> flags[1:0] == 2'b00);

  a_r8_zero_flag: assert property (@(posedge clk) disable iff (rst)
    (valid && op <= 3'd5) |=> flags[3] == ($past(result) == '0));

  a_r8_neg_flag: assert property (@(posedge clk) disable iff (rst)
    (valid && op <= 3'd5) |=> flags[2] == $past(result[W-1]));
endmodule

bind status_alu status_alu_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .valid(valid), .op(op),
  .result(result), .wr_en(wr_en), .flags(flags)
);

// File: tb/tb_status_alu.sv
module tb_status_alu;
  logic        clk = 1'b0;
  logic        rst, valid;
  logic [2:0]  op;
  logic [31:0] src, dst, result;
  logic        wr_en;
  logic [3:0]  flags;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [3:0] exp_flags = 4'b0000;

  always #10 clk = ~clk;

  status_alu dut (
    .clk(clk), .rst(rst), .valid(valid), .op(op), .src(src), .dst(dst),
    .result(result), .wr_en(wr_en), .flags(flags)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic void model(input logic [2:0] o, input logic [31:0] s, input logic [31:0] d,
                                output logic [31:0] r, output logic w, output logic [3:0] f,
                                output logic k);
    logic c, v;
    r = 32'd0; w = 1'b0; c = 1'b0; v = 1'b0; k = 1'b1;
    case (o)
      3'd0: begin
        r = d + s; w = 1'b1;
        c = (r < s) || (r < d);
        v = (d[31] == s[31]) && (r[31] != d[31]);
      end
      3'd1, 3'd2: begin
        r = d - s; w = (o == 3'd1);
        c = s > d;
        v = (d[31] != s[31]) && (r[31] != d[31]);
      end
      3'd3: begin r = d | s; w = 1'b1; end
      3'd4: begin r = d ^ s; w = 1'b1; end
      3'd5: r = d & s;
      default: k = 1'b0;
    endcase
    f = {r == 32'd0, r[31], c, v};
  endfunction

  task automatic step(input logic v_i, input logic [2:0] o, input logic [31:0] s,
                      input logic [31:0] d, input logic r_i, input string req);
    logic [31:0] er; logic ew, ek; logic [3:0] ef;
    @(negedge clk);
    rst = r_i; valid = v_i; op = o; src = s; dst = d;
    model(o, s, d, er, ew, ef, ek);
    #2;
    chk({req, " result"}, result, er);
    chk({req, " wr_en"}, {31'd0, wr_en}, {31'd0, v_i && ew});
    @(posedge clk);
    if (r_i) exp_flags = 4'b0000;
    else if (v_i && ek) exp_flags = ef;
    #2;
    chk({req, " flags"}, {28'd0, flags}, {28'd0, exp_flags});
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1; valid = 1'b1; op = 3'd0; src = 32'hFFFF_FFFF; dst = 32'h0;
    @(posedge clk); @(posedge clk); #2;
    chk("R11 reset", {28'd0, flags}, 32'd0);

    step(1, 3'd0, 32'h0000_0001, 32'hFFFF_FFFF, 0, "R1 R2 R8 add wrap");
    step(1, 3'd0, 32'h0000_0001, 32'h7FFF_FFFF, 0, "R2 add overflow");
    step(1, 3'd0, 32'h8000_0000, 32'h8000_0000, 0, "R2 add neg overflow");
    step(1, 3'd0, 32'h1234_5678, 32'h0000_1111, 0, "R1 add plain");
    step(1, 3'd1, 32'h0000_0001, 32'h0000_0000, 0, "R3 sub borrow");
    step(1, 3'd1, 32'h0000_0001, 32'h8000_0000, 0, "R4 sub overflow");
    step(1, 3'd1, 32'hFFFF_FFFF, 32'h7FFF_FFFF, 0, "R4 sub overflow2");
    step(1, 3'd1, 32'h0000_0005, 32'h0000_0005, 0, "R3 R8 sub zero");
    step(1, 3'd2, 32'h0000_0009, 32'h0000_0009, 0, "R5 cmp equal");
    step(1, 3'd2, 32'h0000_0009, 32'h0000_0003, 0, "R5 cmp borrow");
    step(1, 3'd2, 32'h0000_0001, 32'h8000_0000, 0, "R5 cmp overflow");
    step(1, 3'd3, 32'h8000_0000, 32'h0000_0001, 0, "R6 or neg");
    step(1, 3'd4, 32'hA5A5_A5A5, 32'hA5A5_A5A5, 0, "R6 xor zero");
    step(1, 3'd0, 32'h0000_0001, 32'h7FFF_FFFF, 0, "R2 preset V");
    step(1, 3'd5, 32'h0F0F_0000, 32'hF0F0_0000, 0, "R7 btst zero");
    step(1, 3'd5, 32'h8000_0001, 32'hF000_0000, 0, "R7 btst neg");
    step(1, 3'd0, 32'h8000_0000, 32'h8000_0000, 0, "R2 preset ZCV");
    step(1, 3'd6, 32'h0000_0001, 32'h0000_0002, 0, "R9 code 6");
    step(1, 3'd7, 32'hFFFF_FFFF, 32'h0000_0000, 0, "R9 code 7");
    step(0, 3'd0, 32'h0000_0001, 32'h0000_0002, 0, "R10 idle add");
    step(0, 3'd3, 32'h0000_0000, 32'h8000_0000, 0, "R10 idle or");
    step(1, 3'd1, 32'h0000_0001, 32'h0000_0000, 1, "R11 reset priority");

    for (int i = 0; i < 2000; i++) begin
      logic [31:0] a, b;
      a = $urandom; b = $urandom;
      if (i % 5 == 0) b = a;
      if (i % 7 == 0) a = {a[31], 31'h7FFF_FFFF};
      step(($urandom % 8) != 0, 3'($urandom % 8), a, b, ($urandom % 97) == 0,
           "R1 R3 R5 R6 R7 R8 R9 R10 random");
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule